// File: doc/BRIEF.md
# SDLC Frame Transmitter

This block turns bytes written into a one-byte holding register into a bit-synchronous SDLC line signal. Each frame opens with a flag (0x7E). Address, control, information and check bytes are sent least significant bit first. A 0 is inserted after every run of five 1s in those bytes. A 16-bit frame check sequence is appended, and a flag closes the frame. Between frames the line either stays at logic 1 or repeats flags, as the idle-mode input selects.

The host writes the next byte each time the buffer-empty event pulses. When it runs out of bytes, the tail of the frame is set by two state bits: the abort-on-underrun select and an end-of-message latch, which the host clears with a command pulse. The tail is a check sequence and flag, an abort and flag, or a bare flag. After the check sequence, a final buffer-empty event marks the closing flag. A byte written at that point starts a frame that shares that flag.

`bit_tick` is the enable for one bit time, the falling edge of the transmit clock seen in the system clock domain. `txd` trails the internal serializer by a fixed pipeline, so the first bit of a transferred byte appears a fixed number of bit times after its transfer event.

Top module: `sdlc_tx`

## Requirements
- R1: While reset is asserted and until the first byte or flag-idle request, `txd` is 1 and neither event output pulses.
- R2: With `flag_idle` low and no byte written, `txd` stays 1 (mark idle). A flag already in progress is completed before the line returns to 1.
- R3: With `flag_idle` high and no byte pending, the line repeats the flag 0x7E, sent LSB first as 0,1,1,1,1,1,1,0, with no zero insertion.
- R4: A byte is never taken from the holding register before a complete opening flag has been sent. Writing a byte while the line is marking starts that opening flag by itself.
- R5: `buf_empty_evt` pulses for one cycle when the held byte moves into the shifter. That byte's first bit appears on `txd` exactly 6 bit times after the pulse.
- R6: Within address, control, data and check-sequence bits, a 0 is inserted after every five consecutive 1s. This includes a run that ends on a byte boundary. No insertion is made inside flags or aborts.
- R7: The check sequence is CRC-16 with reflected polynomial 0x8408 and preset 0xFFFF, updated on data bits LSB first. It is sent inverted, low byte first, LSB first. It is preset again at each frame start.
- R8: If the buffer is empty when a data byte ends, the end-of-message latch is clear and `abort_sel` is 0, then `underrun_evt` pulses once, the latch sets, and the check sequence is sent followed by a flag. `buf_empty_evt` pulses when that flag is loaded.
- R9: The same underrun with `abort_sel` 1 sends eight 1s with no insertion, then a flag. It also pulses `underrun_evt` once, and no check sequence and no final buffer-empty event follow.
- R10: With the latch set (its reset state), an underrun sends only a closing flag, and `underrun_evt` does not pulse. `eom_reset` clears the latch.
- R11: A byte written after the final buffer-empty event starts a new frame whose opening flag is the previous closing flag, with exactly one flag between the frames.
- R12: In mark idle with nothing written, exactly one closing flag is sent and the line then returns to 1.
- R13: Between consecutive data-byte transfers within a frame, `buf_empty_evt` pulses are 8 to 10 bit times apart, depending on inserted zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per transmit bit time |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| flag_idle | input | 1 | 1 selects flag idle, 0 selects mark idle |
| abort_sel | input | 1 | 1 sends abort instead of the check sequence on underrun |
| eom_reset | input | 1 | Pulse that clears the end-of-message latch |
| txd | output | 1 | Serial line output |
| buf_empty_evt | output | 1 | Pulse: holding register emptied, or closing flag loaded after the check sequence |
| underrun_evt | output | 1 | Pulse: underrun with the end-of-message latch clear |

## Verification
Each line bit is due on `txd` one bit time after the serializer produces it, plus five lag stages, so a transfer event leads the first bit of its byte by 6 bit times. The scoreboard therefore aligns on the first 0 of the opening flag and then compares one expected bit per bit time. Separate checks tie the first transfer event to bit 8 of the aligned stream. Event counts, the spacing between transfer events and the underrun event are compared after every frame has drained, so no check depends on the exact cycle in which the host wrote.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    K_MARK,
    K_FLAG,
    K_DATA,
    K_CRCL,
    K_CRCH,
    K_ABORT
  } chr_kind_e;

  localparam logic [CHAR_W-1:0] FLAG_PAT  = 8'h7E;
  localparam logic [CHAR_W-1:0] ABORT_PAT = 8'hFF;
  localparam logic [15:0]       CRC_POLY_R = 16'h8408;
  localparam logic [15:0]       CRC_PRESET = 16'hFFFF;
endpackage

// File: rtl/sdlc_tx_crc.sv
module sdlc_tx_crc
  import sdlc_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic        din,
  output logic [15:0] crc_q,
  output logic [15:0] crc_nx
);
  logic fb;

  always_comb begin
    fb     = crc_q[0] ^ din;
    crc_nx = {1'b0, crc_q[15:1]} ^ (fb ? CRC_POLY_R : 16'h0000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_PRESET;
    end else if (init) begin
      crc_q <= CRC_PRESET;
    end else if (en) begin
      crc_q <= crc_nx;
    end
  end
endmodule

// File: rtl/sdlc_tx_holdbuf.sv
module sdlc_tx_holdbuf
  import sdlc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [CHAR_W-1:0] data
);
  logic              full_d;
  logic [CHAR_W-1:0] data_d;

  always_comb begin
    full_d = full;
    data_d = data;
    if (take) full_d = 1'b0;
    if (wr_stb) begin
      full_d = 1'b1;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_d;
      data <= data_d;
    end
  end
endmodule

// File: rtl/sdlc_tx_lag.sv
module sdlc_tx_lag #(
  parameter int DEPTH = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic din,
  output logic dout
);
  generate
    if (DEPTH == 0) begin : g_thru
      assign dout = din;
    end else begin : g_pipe
      logic [DEPTH-1:0] stg_q;
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stg_q[i] <= 1'b1;
          end else if (adv) begin
            if (i == 0) stg_q[i] <= din;
            else        stg_q[i] <= stg_q[i-1];
          end
        end
      end
      assign dout = stg_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sdlc_tx.sv
module sdlc_tx
  import sdlc_tx_pkg::*;
#(
  parameter int TX_LAT    = 6,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_stb,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              flag_idle,
  input  logic              abort_sel,
  input  logic              eom_reset,
  output logic              txd,
  output logic              buf_empty_evt,
  output logic              underrun_evt
);
  localparam int CNT_W  = $clog2(CHAR_W);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);
  localparam int LAG    = TX_LAT - 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(CHAR_W - 1);
  localparam logic [ONES_W-1:0] ONES_LIM = ONES_W'(STUFF_RUN);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  chr_kind_e         kind_q, kind_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic              ser_q, ser_d;
  logic              latch_q, latch_d;
  logic              bevt_q, bevt_d;
  logic              uevt_q, uevt_d;

  logic              buf_full;
  logic [CHAR_W-1:0] buf_data;
  logic              take;
  logic              crc_init, crc_en, crc_bit;
  logic [15:0]       crc_q, crc_nx;
  logic              cur_bit, stuffable;

  sdlc_tx_holdbuf holdbuf_i (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .take    (take),
    .full    (buf_full),
    .data    (buf_data)
  );

  sdlc_tx_crc crc_i (
    .clk    (clk),
    .rst_n  (rst_ni),
    .init   (crc_init),
    .en     (crc_en),
    .din    (crc_bit),
    .crc_q  (crc_q),
    .crc_nx (crc_nx)
  );

  sdlc_tx_lag #(.DEPTH(LAG)) lag_i (
    .clk   (clk),
    .rst_n (rst_ni),
    .adv   (bit_tick),
    .din   (ser_q),
    .dout  (txd)
  );

  // next-state
  always_comb begin
    kind_d    = kind_q;
    sh_d      = sh_q;
    cnt_d     = cnt_q;
    ones_d    = ones_q;
    ser_d     = ser_q;
    latch_d   = eom_reset ? 1'b0 : latch_q;
    bevt_d    = 1'b0;
    uevt_d    = 1'b0;
    take      = 1'b0;
    crc_init  = 1'b0;
    crc_en    = 1'b0;
    crc_bit   = 1'b0;
    cur_bit   = sh_q[0];
    stuffable = (kind_q == K_DATA) || (kind_q == K_CRCL) || (kind_q == K_CRCH);

    if (bit_tick) begin
      if (kind_q == K_MARK) begin
        ser_d = 1'b1;
        if (flag_idle || buf_full) begin
          kind_d = K_FLAG;
          sh_d   = FLAG_PAT;
          cnt_d  = '0;
          ones_d = '0;
        end
      end else if (ones_q == ONES_LIM) begin
        ser_d  = 1'b0;
        ones_d = '0;
      end else begin
        ser_d  = cur_bit;
        sh_d   = {1'b0, sh_q[CHAR_W-1:1]};
        ones_d = (stuffable && cur_bit) ? ones_q + 1'b1 : '0;
        if (kind_q == K_DATA) begin
          crc_en  = 1'b1;
          crc_bit = cur_bit;
        end
        if (cnt_q == CNT_LAST) begin
          cnt_d = '0;
          unique case (kind_q)
            K_FLAG: begin
              if (buf_full) begin
                take     = 1'b1;
                bevt_d   = 1'b1;
                crc_init = 1'b1;
                kind_d   = K_DATA;
                sh_d     = buf_data;
              end else if (flag_idle) begin
                sh_d = FLAG_PAT;
              end else begin
                kind_d = K_MARK;
              end
            end
            K_ABORT: begin
              kind_d = K_FLAG;
              sh_d   = FLAG_PAT;
            end
            K_DATA: begin
              if (buf_full) begin
                take   = 1'b1;
                bevt_d = 1'b1;
                sh_d   = buf_data;
              end else if (!latch_q) begin
                latch_d = 1'b1;
                uevt_d  = 1'b1;
                if (abort_sel) begin
                  kind_d = K_ABORT;
                  sh_d   = ABORT_PAT;
                end else begin
                  kind_d = K_CRCL;
                  sh_d   = ~crc_nx[7:0];
                end
              end else begin
                kind_d = K_FLAG;
                sh_d   = FLAG_PAT;
              end
            end
            K_CRCL: begin
              kind_d = K_CRCH;
              sh_d   = ~crc_q[15:8];
            end
            K_CRCH: begin
              kind_d = K_FLAG;
              sh_d   = FLAG_PAT;
              bevt_d = 1'b1;
            end
            default: kind_d = K_MARK;
          endcase
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= K_MARK;
      sh_q    <= '1;
      cnt_q   <= '0;
      ones_q  <= '0;
      ser_q   <= 1'b1;
      latch_q <= 1'b1;
      bevt_q  <= 1'b0;
      uevt_q  <= 1'b0;
    end else begin
      kind_q  <= kind_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      ones_q  <= ones_d;
      ser_q   <= ser_d;
      latch_q <= latch_d;
      bevt_q  <= bevt_d;
      uevt_q  <= uevt_d;
    end
  end

  assign buf_empty_evt = bevt_q;
  assign underrun_evt  = uevt_q;
endmodule

// File: rtl/sdlc_tx_chk.sv
module sdlc_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic buf_full,
  input logic buf_empty_evt,
  input logic underrun_evt
);
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_empty_evt && underrun_evt)); // R8

  AST_EMPTY_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty_evt |=> !buf_empty_evt); // R13

  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |=> !underrun_evt); // R9

  AST_UNDERRUN_BUF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |-> !$past(buf_full)); // R8

  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> buf_full); // R4
endmodule

bind sdlc_tx sdlc_tx_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_stb        (wr_stb),
  .buf_full      (buf_full),
  .buf_empty_evt (buf_empty_evt),
  .underrun_evt  (underrun_evt)
);

// File: tb/sdlc_tx_tb_top.sv
module sdlc_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_tick;
  logic       wr_stb;
  logic [7:0] wr_data;
  logic       flag_idle;
  logic       abort_sel;
  logic       eom_reset;
  logic       txd;
  logic       buf_empty_evt;
  logic       underrun_evt;

  always #2.5 clk = ~clk;

  sdlc_tx dut_i (
    .clk (clk), .rst_n (rst_n), .bit_tick (bit_tick), .wr_stb (wr_stb),
    .wr_data (wr_data), .flag_idle (flag_idle), .abort_sel (abort_sel),
    .eom_reset (eom_reset), .txd (txd), .buf_empty_evt (buf_empty_evt),
    .underrun_evt (underrun_evt)
  );

  typedef struct { logic b; string tag; } exp_t;
  exp_t q[$];

  int   errs = 0, checks = 0, edge_n = 0;
  int   ev_cnt, un_cnt, start_edge;
  int   ev_t[$];
  logic mon_on = 1'b0, aligned = 1'b0, done = 1'b0;
  int   m_ones;
  logic [15:0] m_crc;
  logic [7:0]  f1 [0:3];
  logic [7:0]  f2 [0:2];

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // ---- reference model pushes ----
  task automatic push_raw(input logic [7:0] v, input string tag);
    for (int i = 0; i < 8; i++) q.push_back('{v[i], tag});
    m_ones = 0;
  endtask

  task automatic push_stuffed(input logic b, input string tag);
    q.push_back('{b, tag});
    if (b) m_ones++; else m_ones = 0;
    if (m_ones == 5) begin
      q.push_back('{1'b0, "R6"});
      m_ones = 0;
    end
  endtask

  task automatic push_data(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = m_crc[0] ^ v[i];
      m_crc = {1'b0, m_crc[15:1]} ^ (fb ? 16'h8408 : 16'h0000);
      push_stuffed(v[i], "R6");
    end
  endtask

  task automatic push_crc();
    logic [15:0] inv;
    inv = ~m_crc;
    for (int i = 0; i < 16; i++) push_stuffed(inv[i], "R7");
  endtask

  // ---- driver ----
  task automatic do_reset();
    rst_n = 1'b0; bit_tick = 1'b1; wr_stb = 1'b0; wr_data = '0;
    flag_idle = 1'b0; abort_sel = 1'b0; eom_reset = 1'b0;
    repeat (3) @(negedge clk);
    ev_cnt = 0; un_cnt = 0; ev_t.delete(); aligned = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] v, input logic arm);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = v; eom_reset = arm;
    @(negedge clk);
    wr_stb = 1'b0; eom_reset = 1'b0;
  endtask

  task automatic wait_ev(input int n);
    while (ev_cnt < n) @(negedge clk);
  endtask

  task automatic run_frame(input int n, input logic arm, input logic abrt,
                           input logic fidle, input int n2);
    int exp_ev, exp_un;
    do_reset();
    abort_sel = abrt;
    m_ones = 0; m_crc = 16'hFFFF;
    push_raw(8'h7E, "R4");
    for (int i = 0; i < n; i++) push_data(f1[i]);
    if (abrt && arm) begin
      push_raw(8'hFF, "R9"); push_raw(8'h7E, "R9");
    end else if (arm) begin
      push_crc(); push_raw(8'h7E, (n2 > 0) ? "R11" : "R8");
    end else begin
      push_raw(8'h7E, "R10");
    end
    if (n2 > 0) begin
      m_crc = 16'hFFFF;
      for (int j = 0; j < n2; j++) push_data(f2[j]);
      push_crc(); push_raw(8'h7E, "R11");
    end
    if (fidle) push_raw(8'h7E, "R3");
    else for (int i = 0; i < 12; i++) q.push_back('{1'b1, "R12"});
    mon_on = 1'b1;
    @(negedge clk);
    flag_idle = fidle;
    wr_byte(f1[0], arm);
    for (int i = 1; i < n; i++) begin
      wait_ev(i);
      wr_byte(f1[i], 1'b0);
    end
    if (n2 > 0) begin
      wait_ev(n + 1);
      wr_byte(f2[0], 1'b1);
      for (int j = 1; j < n2; j++) begin
        wait_ev(n + 1 + j);
        wr_byte(f2[j], 1'b0);
      end
    end
    while (q.size() > 0) @(negedge clk);
    mon_on = 1'b0;
    exp_ev = n + ((arm && !abrt) ? 1 : 0) + ((n2 > 0) ? n2 + 1 : 0);
    exp_un = (arm ? 1 : 0) + ((n2 > 0) ? 1 : 0);
    chk(ev_cnt == exp_ev, arm ? (abrt ? "R9 buf_empty count" : "R8 buf_empty count")
                              : "R10 buf_empty count", ev_cnt, exp_ev);
    chk(un_cnt == exp_un, arm ? "R8 underrun count" : "R10 underrun count", un_cnt, exp_un);
    if (ev_t.size() > 0)
      chk(ev_t[0] + 6 == start_edge + 8, "R5 first bit latency", ev_t[0] + 6, start_edge + 8);
    for (int i = 1; i < n && i < ev_t.size(); i++)
      chk((ev_t[i] - ev_t[i-1] >= 8) && (ev_t[i] - ev_t[i-1] <= 10), "R13 event spacing",
          ev_t[i] - ev_t[i-1], 9);
  endtask

  // ---- monitor / scoreboard ----
  always @(posedge clk) edge_n++;

  always @(negedge clk) begin
    if (buf_empty_evt === 1'b1) begin ev_cnt++; ev_t.push_back(edge_n); end
    if (underrun_evt === 1'b1) un_cnt++;
    if (mon_on && q.size() > 0) begin
      if (!aligned && txd === 1'b0) begin aligned = 1'b1; start_edge = edge_n; end
      if (aligned) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (txd !== it.b) begin
          errs++;
          $display("FAIL %s: txd actual=%0b expected=%0b at edge %0d", it.tag, txd, it.b, edge_n);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    f1[0] = 8'h81; f1[1] = 8'h42; f1[2] = 8'hFF; f1[3] = 8'h42;
    f2[0] = 8'h01; f2[1] = 8'h03; f2[2] = 8'h07;

    // R1 reset state
    rst_n = 1'b0; bit_tick = 1'b1; wr_stb = 1'b0; wr_data = '0;
    flag_idle = 1'b0; abort_sel = 1'b0; eom_reset = 1'b0;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && buf_empty_evt === 1'b0 && underrun_evt === 1'b0, "R1 reset", txd, 1);
    do_reset();
    // R2 mark idle
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (txd !== 1'b1 || buf_empty_evt !== 1'b0) bad++;
    end
    chk(bad == 0, "R2 mark idle", bad, 0);

    // R3 flag idle, then back to mark
    m_ones = 0;
    push_raw(8'h7E, "R3"); push_raw(8'h7E, "R3"); push_raw(8'h7E, "R3");
    mon_on = 1'b1; aligned = 1'b0;
    flag_idle = 1'b1;
    while (q.size() > 0) @(negedge clk);
    mon_on = 1'b0; flag_idle = 1'b0;
    repeat (20) @(negedge clk);
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    chk(bad == 0, "R2 return to mark", bad, 0);
    chk(ev_cnt == 0, "R3 no event in flag idle", ev_cnt, 0);

    run_frame(4, 1'b1, 1'b0, 1'b0, 0);  // R8 CRC tail, R12 mark after
    run_frame(4, 1'b1, 1'b0, 1'b1, 0);  // R8 with flag idle
    run_frame(3, 1'b1, 1'b1, 1'b0, 0);  // R9 abort tail
    run_frame(4, 1'b0, 1'b0, 1'b0, 0);  // R10 latch set
    run_frame(2, 1'b1, 1'b0, 1'b0, 3);  // R11 back-to-back

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule